// File: doc/BRIEF.md
# Power Management Event Aggregator

This block gathers wake-up events from a system's peripherals and turns them into one power management event (PME) output for the chipset. Each source owns one status bit and one enable bit. The ring-indicator inputs, keyboard data and mouse data set their status on a falling edge. The general-purpose pins set their status on an edge whose direction software picks for each pin. The specific-key wake, device interrupts, watchdog, fan tachometer and power button set their status while their input is high. Every raw input is brought into the clock domain through a two-flop synchronizer before it is examined.

Software works through a four-word register port. It reads the status word and clears bits by writing ones. It programs the enable mask, the control word (global enable, output polarity, output buffer type) and the per-pin edge polarity. The status bits latch whether or not the global enable is set. The PME output follows the status bits only when the global enable is on and a set bit is also enabled. The pad drive is split into a value (`pme_o`) and an output enable (`pme_oe_o`). Open-drain operation is emulated by driving only the low level.

Top module: `pme_aggregator`

## Requirements
- R1: After reset the status, enable and edge-polarity words read 0 and the control word reads 0. The output is active low and open-drain, so `pme_o` is 1 and `pme_oe_o` is 0.
- R2: Status bits 0 and 1 (ring indicators), 2 (keyboard data) and 3 (mouse data) set on a high-to-low change of their input. A low-to-high change sets nothing. A bit is readable as set three rising clock edges after the input changes.
- R3: For GPIO pin k, status bit 4+k sets on a rising input edge when bit k of the polarity word (address 3) is 0, and on a falling edge when it is 1. The edge in the other direction sets nothing.
- R4: Status bit 8 (specific key), bits 9 to 12 (device interrupts 0 to 3), bit 13 (watchdog), bit 14 (fan) and bit 15 (power button) set while their synchronized input is high.
- R5: A status bit sets on its event whatever the global enable and the enable mask hold, and no status bit sets without an event.
- R6: Writing the status word (address 0) clears each bit written as 1. Bits written as 0 keep their value.
- R7: When a status bit's event and a write-1 clear of that bit fall in the same cycle, the bit stays set.
- R8: The PME is asserted exactly when control bit 0 (global enable) is 1 and some status bit is 1 whose enable-mask bit (address 1) is also 1.
- R9: Control bit 1 selects the polarity. With 0 the output is active low: `pme_o` is 0 when asserted. With 1 it is active high.
- R10: Control bit 7 selects the buffer. With 0 (open-drain) `pme_oe_o` is 1 exactly when `pme_o` is 0. With 1 (push-pull) `pme_oe_o` is always 1.
- R11: Control-word read bit 8 shows the combined status: 1 while any status bit has its enable bit set. It stays 1 until every such pending bit has been cleared.
- R12: The enable mask, the polarity word and control bits 0, 1 and 7 read back as written. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ri_n_i | input | 2 | Ring-indicator inputs, active low |
| kbd_dat_i | input | 1 | Keyboard data line |
| ms_dat_i | input | 1 | Mouse data line |
| gpio_i | input | N_GPIO | General-purpose wake pins |
| key_wake_i | input | 1 | Specific-key wake request from the keyboard decoder |
| irq_i | input | N_IRQ | Device interrupt requests |
| wdt_i | input | 1 | Watchdog timeout |
| fan_i | input | 1 | Fan tachometer event |
| pwrbtn_i | input | 1 | Power button event |
| reg_addr_i | input | 2 | Register word address: 0 status, 1 enable, 2 control, 3 GPIO polarity |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from the address |
| pme_o | output | 1 | PME pin value |
| pme_oe_o | output | 1 | PME pin output enable |

## Verification
An input change shows up in the status word three rising edges later: two synchronizer stages, then the edge comparison feeding the status register. The bench checks that the bit is still clear after the second edge and set after the third. A register write takes effect at the one edge it spans. Reads and the pin outputs are combinational from the registers, so they are valid in the cycle after that edge. The bench changes inputs and samples outputs on falling edges. For table rows it waits four edges before reading, so each row's result has settled.

// File: rtl/pme_pkg.sv
package pme_pkg;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_STS = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_MSK = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CTL = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_POL = 2'd3;

  localparam int unsigned CTL_GEN_BIT = 0;
  localparam int unsigned CTL_POL_BIT = 1;
  localparam int unsigned CTL_BUF_BIT = 7;
  localparam int unsigned CTL_SUM_BIT = 8;

  // Number of fixed falling-edge sources: two ring indicators, keyboard, mouse
  localparam int unsigned N_FIXED = 4;

  typedef struct packed {
    logic push_pull;
    logic act_high;
    logic glob_en;
  } pme_ctl_t;

endpackage

// File: rtl/pme_sync.sv
module pme_sync #(
  parameter int unsigned          W       = 8,
  parameter logic [W-1:0]         RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/pme_edge.sv
module pme_edge #(
  parameter int unsigned  W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] sel_rise_i,
  input  logic [W-1:0] sel_fall_i,
  input  logic [W-1:0] sel_lvl_i,
  output logic [W-1:0] ev_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RST_VAL;
    end else begin
      prev_q <= s_i;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rise, fall;
    always_comb begin
      rise    = s_i[i] & ~prev_q[i];
      fall    = ~s_i[i] & prev_q[i];
      ev_o[i] = (sel_lvl_i[i]  & s_i[i])
              | (sel_rise_i[i] & rise)
              | (sel_fall_i[i] & fall);
    end
  end

endmodule

// File: rtl/pme_regs.sv
module pme_regs
  import pme_pkg::*;
#(
  parameter int unsigned NSRC   = 16,
  parameter int unsigned N_GPIO = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   ev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NSRC-1:0]   sts_o,
  output logic [N_GPIO-1:0] pol_o,
  output pme_ctl_t          ctl_o,
  output logic              pme_act_o
);

  logic [NSRC-1:0]   sts_q, sts_d, clr_mask;
  logic [NSRC-1:0]   msk_q, msk_d;
  logic [N_GPIO-1:0] pol_q, pol_d;
  pme_ctl_t          ctl_q, ctl_d;
  logic              msk_en, pol_en, ctl_en, sts_wr;
  logic              sum;

  // next state
  always_comb begin
    sts_wr   = we_i && (addr_i == ADR_STS);
    msk_en   = we_i && (addr_i == ADR_MSK);
    ctl_en   = we_i && (addr_i == ADR_CTL);
    pol_en   = we_i && (addr_i == ADR_POL);
    clr_mask = sts_wr ? wdata_i[NSRC-1:0] : '0;
    // an event in the clearing cycle wins
    sts_d    = (sts_q & ~clr_mask) | ev_i;
    msk_d    = msk_en ? wdata_i[NSRC-1:0] : msk_q;
    pol_d    = pol_en ? wdata_i[N_GPIO-1:0] : pol_q;
    if (ctl_en) begin
      ctl_d.push_pull = wdata_i[CTL_BUF_BIT];
      ctl_d.act_high  = wdata_i[CTL_POL_BIT];
      ctl_d.glob_en   = wdata_i[CTL_GEN_BIT];
    end else begin
      ctl_d = ctl_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= '0;
      pol_q <= '0;
      ctl_q <= '0;
    end else begin
      sts_q <= sts_d;
      msk_q <= msk_d;
      pol_q <= pol_d;
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    sum       = |(sts_q & msk_q);
    pme_act_o = ctl_q.glob_en & sum;
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_STS: rdata_o[NSRC-1:0] = sts_q;
      ADR_MSK: rdata_o[NSRC-1:0] = msk_q;
      ADR_CTL: begin
        rdata_o[CTL_GEN_BIT] = ctl_q.glob_en;
        rdata_o[CTL_POL_BIT] = ctl_q.act_high;
        rdata_o[CTL_BUF_BIT] = ctl_q.push_pull;
        rdata_o[CTL_SUM_BIT] = sum;
      end
      default: rdata_o[N_GPIO-1:0] = pol_q;
    endcase
  end

  assign sts_o = sts_q;
  assign pol_o = pol_q;
  assign ctl_o = ctl_q;

endmodule

// File: rtl/pme_pin.sv
module pme_pin
  import pme_pkg::*;
(
  input  logic     act_i,
  input  pme_ctl_t ctl_i,
  output logic     pin_o,
  output logic     oe_o
);

  logic level;

  always_comb begin
    level = ctl_i.act_high ? act_i : ~act_i;
    pin_o = level;
    // open-drain: only the low level is driven
    oe_o  = ctl_i.push_pull ? 1'b1 : ~level;
  end

endmodule

// File: rtl/pme_aggregator.sv
module pme_aggregator
  import pme_pkg::*;
#(
  parameter int unsigned N_GPIO = 4,
  parameter int unsigned N_IRQ  = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          ri_n_i,
  input  logic                kbd_dat_i,
  input  logic                ms_dat_i,
  input  logic [N_GPIO-1:0]   gpio_i,
  input  logic                key_wake_i,
  input  logic [N_IRQ-1:0]    irq_i,
  input  logic                wdt_i,
  input  logic                fan_i,
  input  logic                pwrbtn_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                pme_o,
  output logic                pme_oe_o
);

  localparam int unsigned B_GPIO = N_FIXED;
  localparam int unsigned B_KEY  = B_GPIO + N_GPIO;
  localparam int unsigned N_LVL  = 1 + N_IRQ + 3;
  localparam int unsigned NSRC   = B_KEY + N_LVL;
  localparam logic [NSRC-1:0] IDLE_VAL = {{(NSRC-N_FIXED){1'b0}}, {N_FIXED{1'b1}}};

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NSRC-1:0]   raw_vec, sync_vec, ev_vec;
  logic [NSRC-1:0]   sel_rise, sel_fall, sel_lvl;
  logic [NSRC-1:0]   sts_q;
  logic [N_GPIO-1:0] gpio_pol;
  pme_ctl_t          ctl_q;
  logic              pme_act;

  assign raw_vec = {pwrbtn_i, fan_i, wdt_i, irq_i, key_wake_i,
                    gpio_i, ms_dat_i, kbd_dat_i, ri_n_i};

  always_comb begin
    sel_lvl  = {{N_LVL{1'b1}}, {B_KEY{1'b0}}};
    sel_fall = {{N_LVL{1'b0}}, gpio_pol, {N_FIXED{1'b1}}};
    sel_rise = {{N_LVL{1'b0}}, ~gpio_pol, {N_FIXED{1'b0}}};
  end

  pme_sync #(.W(NSRC), .RST_VAL(IDLE_VAL)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (raw_vec),
    .q_o   (sync_vec)
  );

  pme_edge #(.W(NSRC), .RST_VAL(IDLE_VAL)) u_edge (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .s_i        (sync_vec),
    .sel_rise_i (sel_rise),
    .sel_fall_i (sel_fall),
    .sel_lvl_i  (sel_lvl),
    .ev_o       (ev_vec)
  );

  pme_regs #(.NSRC(NSRC), .N_GPIO(N_GPIO), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ev_i      (ev_vec),
    .addr_i    (reg_addr_i),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .sts_o     (sts_q),
    .pol_o     (gpio_pol),
    .ctl_o     (ctl_q),
    .pme_act_o (pme_act)
  );

  pme_pin u_pin (
    .act_i (pme_act),
    .ctl_i (ctl_q),
    .pin_o (pme_o),
    .oe_o  (pme_oe_o)
  );

endmodule

// File: rtl/pme_aggregator_chk.sv
module pme_aggregator_chk
  import pme_pkg::*;
#(
  parameter int unsigned NSRC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   ev,
  input logic [NSRC-1:0]   sts,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [NSRC-1:0]   wdata,
  input logic              glob_en,
  input logic              act_high,
  input logic              push_pull,
  input logic              pme_o,
  input logic              pme_oe
);

  // R7: every event is visible in status a cycle later, even under a clear
  p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((sts & $past(ev)) == $past(ev)));

  // R5: a status bit never rises without an event
  p_no_spurious_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((sts & ~$past(sts) & ~$past(ev)) == '0));

  // R6: bits written as one with no concurrent event are cleared
  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADR_STS && ((wdata & ~ev) != '0))
      |=> ((sts & $past(wdata & ~ev)) == '0));

  // R8: with the global enable off the pin sits at its inactive level
  p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> (pme_o != act_high));

  // R10: open-drain drives only the low level
  p_od_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_pull && pme_o) |-> !pme_oe);

  p_od_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_pull && !pme_o) |-> pme_oe);

  // R10: push-pull always drives
  p_pp_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push_pull |-> pme_oe);

endmodule

bind pme_aggregator pme_aggregator_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ev        (ev_vec),
  .sts       (sts_q),
  .we        (reg_we_i),
  .addr      (reg_addr_i),
  .wdata     (reg_wdata_i[NSRC-1:0]),
  .glob_en   (ctl_q.glob_en),
  .act_high  (ctl_q.act_high),
  .push_pull (ctl_q.push_pull),
  .pme_o     (pme_o),
  .pme_oe    (pme_oe_o)
);

// File: tb/sim_pme_aggregator.sv
module sim_pme_aggregator;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDLE = 16'h000F;

  // row: {gpio polarity[3:0], raw inputs[15:0], expected status[15:0]}
  localparam int NROW = 12;
  localparam logic [35:0] VEC [NROW] = '{
    {4'h0, 16'h000E, 16'h0001},   // R2 ri0 falls
    {4'h0, 16'h000D, 16'h0002},   // R2 ri1 falls
    {4'h0, 16'h000B, 16'h0004},   // R2 keyboard falls
    {4'h0, 16'h0007, 16'h0008},   // R2 mouse falls
    {4'h0, 16'h001F, 16'h0010},   // R3 gpio0 rises
    {4'h0, 16'h00FF, 16'h00F0},   // R3 all gpio rise
    {4'hF, 16'h00FF, 16'h0000},   // R3 rising ignored when inverted
    {4'h0, 16'h010F, 16'h0100},   // R4 key wake
    {4'h0, 16'h1E0F, 16'h1E00},   // R4 interrupts
    {4'h0, 16'hE00F, 16'hE000},   // R4 wdt fan power
    {4'h0, 16'h000F, 16'h0000},   // R5 no event
    {4'h0, 16'hFFF0, 16'hFFFF}    // R2 R3 R4 all at once
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ri_n;
  logic        kbd, ms;
  logic [3:0]  gpio;
  logic        key;
  logic [3:0]  irq;
  logic        wdt, fan, pwr;
  logic [1:0]  addr;
  logic        we;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        pme, pme_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pme_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .ri_n_i(ri_n), .kbd_dat_i(kbd), .ms_dat_i(ms),
    .gpio_i(gpio), .key_wake_i(key), .irq_i(irq), .wdt_i(wdt), .fan_i(fan),
    .pwrbtn_i(pwr), .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pme_o(pme), .pme_oe_o(pme_oe)
  );

  task automatic set_raw(input logic [15:0] r);
    ri_n = r[1:0];  kbd = r[2];  ms = r[3];  gpio = r[7:4];
    key  = r[8];    irq = r[12:9]; wdt = r[13]; fan = r[14]; pwr = r[15];
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; we = 1'b0; addr = 2'd0; wdata = '0;
    set_raw(IDLE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    rd(2'd0, d); check("R1 status", d, 16'h0000);
    rd(2'd1, d); check("R1 enable", d, 16'h0000);
    rd(2'd2, d); check("R1 control", d, 16'h0000);
    rd(2'd3, d); check("R1 polarity", d, 16'h0000);
    check("R1 pme_o", pme, 1'b1);
    check("R1 pme_oe", pme_oe, 1'b0);

    // table walk
    for (int i = 0; i < NROW; i++) begin
      wr(2'd3, {12'h0, VEC[i][35:32]});
      @(negedge clk);
      set_raw(VEC[i][31:16]);
      settle();
      rd(2'd0, d);
      check($sformatf("R2/R3/R4 row %0d", i), d, VEC[i][15:0]);
      check($sformatf("R5 row %0d pme idle", i), pme, 1'b1);
      set_raw(IDLE);
      settle();
      wr(2'd0, 16'hFFFF);
      wr(2'd3, 16'h0000);
      rd(2'd0, d);
      check($sformatf("R6 row %0d cleared", i), d, 16'h0000);
    end

    // R2 latency: set after the third rising edge, not before
    @(negedge clk);
    ri_n[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    peek(2'd0, d); check("R2 not yet after two edges", d, 16'h0000);
    @(negedge clk);
    peek(2'd0, d); check("R2 set after third edge", d, 16'h0001);
    wr(2'd0, 16'h0001);
    ri_n[0] = 1'b1;   // rising: must not set
    settle();
    rd(2'd0, d); check("R2 rising ignored", d, 16'h0000);

    // R3 falling edge with inverted polarity
    wr(2'd3, 16'h0001);
    @(negedge clk); gpio[0] = 1'b1;
    settle();
    rd(2'd0, d); check("R3 inverted rising ignored", d, 16'h0000);
    gpio[0] = 1'b0;
    settle();
    rd(2'd0, d); check("R3 inverted falling sets", d, 16'h0010);
    wr(2'd0, 16'hFFFF);
    wr(2'd3, 16'h0000);

    // R5/R8 status latches with enable off, pin gated
    wdt = 1'b1; pwr = 1'b1;
    settle();
    wdt = 1'b0; pwr = 1'b0;
    settle();
    rd(2'd0, d); check("R5 latch without enable", d, 16'hA000);
    check("R8 gated no mask", pme, 1'b1);
    wr(2'd1, 16'hA000);
    rd(2'd2, d); check("R11 combined with enable off", d, 16'h0100);
    check("R8 gated global off", pme, 1'b1);
    check("R10 od released", pme_oe, 1'b0);
    wr(2'd2, 16'h0001);
    check("R8 asserted low", pme, 1'b0);
    check("R10 od drives low", pme_oe, 1'b1);

    // R9/R10 polarity and buffer
    wr(2'd2, 16'h0003);
    check("R9 active high", pme, 1'b1);
    check("R10 od high released", pme_oe, 1'b0);
    wr(2'd2, 16'h0083);
    check("R10 push-pull high", {pme, pme_oe}, 2'b11);
    wr(2'd2, 16'h0081);
    check("R10 push-pull low", {pme, pme_oe}, 2'b01);
    rd(2'd2, d); check("R12 control readback", d, 16'h0181);
    wr(2'd2, 16'h0001);

    // R6/R11 partial clears
    wr(2'd0, 16'h0000);
    rd(2'd0, d); check("R6 zero write keeps", d, 16'hA000);
    wr(2'd0, 16'h2000);
    rd(2'd0, d); check("R6 one bit cleared", d, 16'h8000);
    rd(2'd2, d); check("R11 still pending", d, 16'h0101);
    check("R8 still asserted", pme, 1'b0);
    wr(2'd0, 16'h8000);
    rd(2'd2, d); check("R11 all cleared", d, 16'h0001);
    check("R8 deasserted", pme, 1'b1);

    // R7 event and clear in the same cycle
    wdt = 1'b1;
    settle();
    wr(2'd0, 16'h2000);
    rd(2'd0, d); check("R7 set wins", d, 16'h2000);
    wdt = 1'b0;
    settle();
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); check("R7 clears once idle", d, 16'h0000);

    // R12 readback
    wr(2'd1, 16'h5A5A);
    rd(2'd1, d); check("R12 enable readback", d, 16'h5A5A);
    wr(2'd3, 16'hFFFA);
    rd(2'd3, d); check("R12 polarity readback", d, 16'h000A);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule